// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block is the in-order completion point of a speculative out-of-order core. It is a circular array of `DEPTH` entries. At dispatch it hands out up to `ALLOC_W` entries per cycle in program order. The slot index of each entry is returned as the producer tag that the execution units later present when they write back.

Write-back marks an entry complete and records its result. For a store it records the store address and data. For a branch it records the resolved target and a misprediction flag. When a branch resolves as mispredicted, every younger entry is dropped in that same cycle, and the correct fetch address is driven to the front end.

Complete entries leave from the head in program order, up to `RET_W` per cycle. A retiring entry produces a register-file write, or a memory write if it is a store. Memory is therefore never written on a speculative path.

Top module: `spec_reorder_buf`

## Requirements
- R1: After reset the buffer is empty. No retire, register write, store or redirect is signalled, and a full dispatch group can be granted.
- R2: Dispatch slot i is granted only if it is requested, all lower slots are granted, and fewer than the number of free entries precede it. No slot is granted while the buffer is full.
- R3: Each cycle the longest run of complete entries starting at the head retires, capped at `RET_W`. Retire lanes are filled from lane 0 upward in program order.
- R4: A retiring entry of kind ALU (`2'd0`) or branch (`2'd2`) asserts a register write with its destination and its written-back value.
- R5: A retiring store (kind `2'd1`) asserts a memory write with its written-back address and data. It never writes a register, and no store reaches memory before it retires.
- R6: A mispredicted write-back to an occupied entry raises `redir_vld` in the same cycle, with `redir_pc` equal to that port's `wb_addr`. All entries younger than the branch are discarded, and no dispatch is granted that cycle. If several such write-backs arrive together, the oldest branch wins.
- R7: Granted slot i receives tag (head + occupancy + i) mod `DEPTH`, so tags follow program order around the ring.
- R8: A retiring entry that carries the misprediction flag is the last entry retired in its cycle.
- R9: A retiring entry whose destination is register 0 produces no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_vld | input | ALLOC_W | Dispatch request per slot |
| disp_kind | input | ALLOC_W x 2 | Entry kind per slot: 0 ALU/load, 1 store, 2 branch |
| disp_rd | input | ALLOC_W x RAW | Destination register per slot |
| disp_gnt | output | ALLOC_W | Dispatch grant per slot |
| disp_tag | output | ALLOC_W x IW | Producer tag per slot |
| wb_vld | input | WB_W | Write-back valid per port |
| wb_tag | input | WB_W x IW | Tag being completed |
| wb_value | input | WB_W x XLEN | Result, or store data |
| wb_addr | input | WB_W x XLEN | Store address, or resolved branch target |
| wb_mispred | input | WB_W | Branch resolved as mispredicted |
| redir_vld | output | 1 | Fetch redirect |
| redir_pc | output | XLEN | Correct fetch address |
| ret_vld | output | RET_W | Retire lane active |
| rf_we | output | RET_W | Register write per lane |
| rf_addr | output | RET_W x RAW | Register index per lane |
| rf_data | output | RET_W x XLEN | Register data per lane |
| st_we | output | RET_W | Store commit per lane |
| st_addr | output | RET_W x XLEN | Store address per lane |
| st_data | output | RET_W x XLEN | Store data per lane |

## Verification
Squash and retirement can happen in the same cycle. While a mispredicting branch is written back, older entries that are already complete leave from the head, and a new dispatch group is being requested. The occupancy after that cycle must equal the branch's age plus one, minus the entries retired.

The bench provokes this with a long mixed phase that has dispatch, out-of-order completion and random branch mispredictions all enabled. It judges every cycle against a queue-based model that applies write-back, then truncation, then retirement pops, then dispatch pushes. Every output lane, the grants and the redirect are compared against that model.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2
  } kind_e;
endpackage

// File: rtl/rob_alloc.sv
module rob_alloc #(
  parameter int DEPTH = 8,
  parameter int AW    = 2,
  parameter int IW    = 3,
  parameter int CW    = 4
) (
  input  logic [IW-1:0]         tail,
  input  logic [CW-1:0]         count,
  input  logic                  block,
  input  logic [AW-1:0]         req,
  output logic [AW-1:0]         gnt,
  output logic [AW-1:0][IW-1:0] tag,
  output logic [CW-1:0]         n_alloc
);
  function automatic logic [CW-1:0] room(input logic [CW-1:0] c);
    return CW'(DEPTH) - c;
  endfunction

  always_comb begin
    logic ok;
    ok      = !block;
    n_alloc = '0;
    for (int i = 0; i < AW; i++) begin
      tag[i] = tail + IW'(i);
      ok     = ok && req[i] && (CW'(i) < room(count));
      gnt[i] = ok;
      if (ok) n_alloc = n_alloc + CW'(1);
    end
  end
endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
  parameter int DEPTH = 8,
  parameter int RW    = 2,
  parameter int IW    = 3,
  parameter int CW    = 4
) (
  input  logic [IW-1:0]    head,
  input  logic [CW-1:0]    count,
  input  logic [DEPTH-1:0] done_v,
  input  logic [DEPTH-1:0] mis_v,
  output logic [RW-1:0]    mask,
  output logic [CW-1:0]    n_ret
);
  always_comb begin
    logic go;
    logic [IW-1:0] idx;
    go    = 1'b1;
    n_ret = '0;
    for (int i = 0; i < RW; i++) begin
      idx     = head + IW'(i);
      go      = go && (CW'(i) < count) && done_v[idx];
      mask[i] = go;
      if (go) begin
        n_ret = n_ret + CW'(1);
        if (mis_v[idx]) go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rob_flush.sv
module rob_flush #(
  parameter int WBW = 2,
  parameter int IW  = 3,
  parameter int CW  = 4,
  parameter int PW  = 1
) (
  input  logic [IW-1:0]          head,
  input  logic [CW-1:0]          count,
  input  logic [WBW-1:0]         wb_vld,
  input  logic [WBW-1:0]         wb_mis,
  input  logic [WBW-1:0][IW-1:0] wb_tag,
  output logic                   flush,
  output logic [PW-1:0]          fl_port,
  output logic [IW-1:0]          fl_age,
  output logic [WBW-1:0]         wb_ok
);
  function automatic logic [IW-1:0] age_of(input logic [IW-1:0] t, input logic [IW-1:0] h);
    return t - h;
  endfunction

  always_comb begin
    logic [IW-1:0] a;
    flush   = 1'b0;
    fl_port = '0;
    fl_age  = '0;
    for (int j = 0; j < WBW; j++) begin
      a = age_of(wb_tag[j], head);
      if (wb_vld[j] && wb_mis[j] && (CW'(a) < count) && (!flush || a < fl_age)) begin
        flush   = 1'b1;
        fl_port = PW'(j);
        fl_age  = a;
      end
    end
    for (int j = 0; j < WBW; j++) begin
      a        = age_of(wb_tag[j], head);
      wb_ok[j] = wb_vld[j] && (CW'(a) < count) && (!flush || a <= fl_age);
    end
  end
endmodule

// File: rtl/spec_reorder_buf.sv
module spec_reorder_buf #(
  parameter int DEPTH   = 8,
  parameter int ALLOC_W = 2,
  parameter int RET_W   = 2,
  parameter int WB_W    = 2,
  parameter int XLEN    = 32,
  parameter int RAW     = 5,
  localparam int IW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int PW     = (WB_W > 1) ? $clog2(WB_W) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ALLOC_W-1:0]            disp_vld,
  input  logic [ALLOC_W-1:0][1:0]       disp_kind,
  input  logic [ALLOC_W-1:0][RAW-1:0]   disp_rd,
  output logic [ALLOC_W-1:0]            disp_gnt,
  output logic [ALLOC_W-1:0][IW-1:0]    disp_tag,
  input  logic [WB_W-1:0]               wb_vld,
  input  logic [WB_W-1:0][IW-1:0]       wb_tag,
  input  logic [WB_W-1:0][XLEN-1:0]     wb_value,
  input  logic [WB_W-1:0][XLEN-1:0]     wb_addr,
  input  logic [WB_W-1:0]               wb_mispred,
  output logic                          redir_vld,
  output logic [XLEN-1:0]               redir_pc,
  output logic [RET_W-1:0]              ret_vld,
  output logic [RET_W-1:0]              rf_we,
  output logic [RET_W-1:0][RAW-1:0]     rf_addr,
  output logic [RET_W-1:0][XLEN-1:0]    rf_data,
  output logic [RET_W-1:0]              st_we,
  output logic [RET_W-1:0][XLEN-1:0]    st_addr,
  output logic [RET_W-1:0][XLEN-1:0]    st_data
);
  import rob_pkg::*;

  typedef struct packed {
    kind_e           kind;
    logic [RAW-1:0]  rd;
    logic [XLEN-1:0] val;
    logic [XLEN-1:0] addr;
    logic            done;
    logic            mis;
  } ent_t;

  ent_t          ent_q [DEPTH];
  logic [IW-1:0] head_q;
  logic [CW-1:0] count_q;

  // named internal events, observed by the checker
  logic [IW-1:0]    tail;
  logic [DEPTH-1:0] done_v, mis_v;
  logic [CW-1:0]    n_alloc, n_ret;
  logic             flush;
  logic [PW-1:0]    fl_port;
  logic [IW-1:0]    fl_age;
  logic [WB_W-1:0]  wb_ok;
  logic [RET_W-1:0] ret_mask;

  assign tail = head_q + count_q[IW-1:0];

  for (genvar s = 0; s < DEPTH; s++) begin : g_vec
    assign done_v[s] = ent_q[s].done;
    assign mis_v[s]  = ent_q[s].mis;
  end

  rob_flush #(.WBW(WB_W), .IW(IW), .CW(CW), .PW(PW)) u_flush (
    .head(head_q), .count(count_q), .wb_vld(wb_vld), .wb_mis(wb_mispred),
    .wb_tag(wb_tag), .flush(flush), .fl_port(fl_port), .fl_age(fl_age), .wb_ok(wb_ok)
  );

  rob_alloc #(.DEPTH(DEPTH), .AW(ALLOC_W), .IW(IW), .CW(CW)) u_alloc (
    .tail(tail), .count(count_q), .block(flush), .req(disp_vld),
    .gnt(disp_gnt), .tag(disp_tag), .n_alloc(n_alloc)
  );

  rob_retire #(.DEPTH(DEPTH), .RW(RET_W), .IW(IW), .CW(CW)) u_retire (
    .head(head_q), .count(count_q), .done_v(done_v), .mis_v(mis_v),
    .mask(ret_mask), .n_ret(n_ret)
  );

  function automatic logic [CW-1:0] next_count(
    input logic f, input logic [IW-1:0] fa, input logic [CW-1:0] c,
    input logic [CW-1:0] na, input logic [CW-1:0] nr);
    return f ? (CW'(fa) + CW'(1) - nr) : (c + na - nr);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
      for (int s = 0; s < DEPTH; s++) begin
        ent_q[s].done <= 1'b0;
        ent_q[s].mis  <= 1'b0;
      end
    end else begin
      for (int j = 0; j < WB_W; j++) begin
        if (wb_ok[j]) begin
          ent_q[wb_tag[j]].done <= 1'b1;
          ent_q[wb_tag[j]].val  <= wb_value[j];
          ent_q[wb_tag[j]].addr <= wb_addr[j];
          ent_q[wb_tag[j]].mis  <= wb_mispred[j];
        end
      end
      for (int i = 0; i < ALLOC_W; i++) begin
        if (disp_gnt[i]) begin
          ent_q[disp_tag[i]].kind <= kind_e'(disp_kind[i]);
          ent_q[disp_tag[i]].rd   <= disp_rd[i];
          ent_q[disp_tag[i]].val  <= '0;
          ent_q[disp_tag[i]].addr <= '0;
          ent_q[disp_tag[i]].done <= 1'b0;
          ent_q[disp_tag[i]].mis  <= 1'b0;
        end
      end
      head_q  <= head_q + n_ret[IW-1:0];
      count_q <= next_count(flush, fl_age, count_q, n_alloc, n_ret);
    end
  end

  assign redir_vld = flush;
  assign redir_pc  = wb_addr[fl_port];

  for (genvar g = 0; g < RET_W; g++) begin : g_lane
    ent_t e;
    assign e          = ent_q[head_q + IW'(g)];
    assign ret_vld[g] = ret_mask[g];
    assign rf_we[g]   = ret_mask[g] && (e.kind != K_STORE) && (e.rd != '0);
    assign rf_addr[g] = e.rd;
    assign rf_data[g] = e.val;
    assign st_we[g]   = ret_mask[g] && (e.kind == K_STORE);
    assign st_addr[g] = e.addr;
    assign st_data[g] = e.val;
  end
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH   = 8,
  parameter int ALLOC_W = 2,
  parameter int RET_W   = 2,
  parameter int RAW     = 5,
  parameter int CW      = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [CW-1:0]             count,
  input logic [CW-1:0]             n_alloc,
  input logic [CW-1:0]             n_ret,
  input logic                      flush,
  input logic [ALLOC_W-1:0]        disp_gnt,
  input logic [RET_W-1:0]          ret_vld,
  input logic [RET_W-1:0]          rf_we,
  input logic [RET_W-1:0][RAW-1:0] rf_addr,
  input logic [RET_W-1:0]          st_we,
  input logic                      redir_vld
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R2
  AST_FULL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> (disp_gnt == '0)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (count == $past(count) + $past(n_alloc) - $past(n_ret))); // R3
  AST_FLUSH_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count <= $past(count))); // R6
  AST_FLUSH_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |-> (disp_gnt == '0)); // R6
  AST_RETIRE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_vld & (ret_vld + RET_W'(1))) == '0)); // R3

  for (genvar g = 0; g < RET_W; g++) begin : g_lane
    AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_we[g] && rf_we[g])); // R5
    AST_X0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we[g] |-> (rf_addr[g] != '0)); // R9
    AST_LANE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we[g] || st_we[g]) |-> ret_vld[g]); // R4
  end
endmodule

bind spec_reorder_buf rob_checker #(
  .DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W), .RAW(RAW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count_q), .n_alloc(n_alloc), .n_ret(n_ret),
  .flush(flush), .disp_gnt(disp_gnt), .ret_vld(ret_vld), .rf_we(rf_we),
  .rf_addr(rf_addr), .st_we(st_we), .redir_vld(redir_vld)
);

// File: tb/sim_spec_reorder_buf.sv
`timescale 1ns/1ps
module sim_spec_reorder_buf;
  localparam int DEPTH = 8, AW = 2, RW = 2, WBW = 2, XLEN = 32, RAW = 5;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0]             disp_vld;
  logic [AW-1:0][1:0]        disp_kind;
  logic [AW-1:0][RAW-1:0]    disp_rd;
  logic [AW-1:0]             disp_gnt;
  logic [AW-1:0][IW-1:0]     disp_tag;
  logic [WBW-1:0]            wb_vld;
  logic [WBW-1:0][IW-1:0]    wb_tag;
  logic [WBW-1:0][XLEN-1:0]  wb_value, wb_addr;
  logic [WBW-1:0]            wb_mispred;
  logic                      redir_vld;
  logic [XLEN-1:0]           redir_pc;
  logic [RW-1:0]             ret_vld, rf_we, st_we;
  logic [RW-1:0][RAW-1:0]    rf_addr;
  logic [RW-1:0][XLEN-1:0]   rf_data, st_addr, st_data;

  spec_reorder_buf #(.DEPTH(DEPTH), .ALLOC_W(AW), .RET_W(RW), .WB_W(WBW),
                     .XLEN(XLEN), .RAW(RAW)) u0 (.*);

  typedef struct {
    int          kind;
    int          rd;
    logic [31:0] val;
    logic [31:0] addr;
    bit          done;
    bit          mis;
  } m_t;
  m_t q[$];
  int head_tag = 0;
  int total = 0, bad = 0;
  int n_flush_ret = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // reference: compare this cycle's outputs, then advance the model
  task automatic eval_cycle();
    int cnt, fage, fport, nret, a, keep;
    bit fl, go;
    bit eg[AW];
    cnt = q.size();
    fl = 0; fage = 0; fport = 0;
    for (int j = 0; j < WBW; j++) begin
      a = (int'(wb_tag[j]) - head_tag + DEPTH) % DEPTH;
      if (wb_vld[j] && wb_mispred[j] && a < cnt && (!fl || a < fage)) begin
        fl = 1; fage = a; fport = j;
      end
    end
    chk(redir_vld == fl, "R6", "redir_vld", redir_vld, fl);
    if (fl) chk(redir_pc == wb_addr[fport], "R6", "redir_pc", redir_pc, wb_addr[fport]);
    go = !fl;
    for (int i = 0; i < AW; i++) begin
      go = go && disp_vld[i] && (i < DEPTH - cnt);
      eg[i] = go;
      chk(disp_gnt[i] == go, "R2", $sformatf("gnt[%0d]", i), disp_gnt[i], go);
      if (go) chk(int'(disp_tag[i]) == (head_tag + cnt + i) % DEPTH, "R7",
                  $sformatf("tag[%0d]", i), disp_tag[i], (head_tag + cnt + i) % DEPTH);
    end
    nret = 0; go = 1;
    for (int i = 0; i < RW; i++) begin
      bit r, ew, es;
      r = go && i < cnt && q[i].done;
      go = r && !q[i].mis; // R8: a flagged branch closes the group
      if (r) nret++;
      ew = r && q[i].kind != 1 && q[i].rd != 0;
      es = r && q[i].kind == 1;
      chk(ret_vld[i] == r, "R3", $sformatf("ret_vld[%0d]", i), ret_vld[i], r);
      chk(rf_we[i] == ew, (r && q[i].rd == 0) ? "R9" : "R4",
          $sformatf("rf_we[%0d]", i), rf_we[i], ew);
      chk(st_we[i] == es, "R5", $sformatf("st_we[%0d]", i), st_we[i], es);
      if (ew) begin
        chk(int'(rf_addr[i]) == q[i].rd, "R4", "rf_addr", rf_addr[i], q[i].rd);
        chk(rf_data[i] == q[i].val, "R4", "rf_data", rf_data[i], q[i].val);
      end
      if (es) begin
        chk(st_addr[i] == q[i].addr, "R5", "st_addr", st_addr[i], q[i].addr);
        chk(st_data[i] == q[i].val, "R5", "st_data", st_data[i], q[i].val);
      end
    end
    if (fl && nret > 0) n_flush_ret++;
    for (int j = 0; j < WBW; j++) begin
      a = (int'(wb_tag[j]) - head_tag + DEPTH) % DEPTH;
      if (wb_vld[j] && a < cnt && (!fl || a <= fage)) begin
        q[a].done = 1; q[a].val = wb_value[j]; q[a].addr = wb_addr[j];
        q[a].mis = wb_mispred[j];
      end
    end
    if (fl) begin
      keep = fage + 1;
      while (q.size() > keep) void'(q.pop_back());
    end
    for (int i = 0; i < nret; i++) void'(q.pop_front());
    head_tag = (head_tag + nret) % DEPTH;
    for (int i = 0; i < AW; i++) if (eg[i]) begin
      m_t m;
      m.kind = disp_kind[i]; m.rd = disp_rd[i]; m.val = 0; m.addr = 0;
      m.done = 0; m.mis = 0;
      q.push_back(m);
    end
  endtask

  task automatic gen(input int p_disp, input int p_wb, input int p_mis);
    bit used[DEPTH];
    for (int i = 0; i < AW; i++) begin
      disp_vld[i]  = ($urandom % 100) < p_disp;
      disp_kind[i] = 2'($urandom % 3);
      disp_rd[i]   = ($urandom % 6 == 0) ? '0 : RAW'($urandom);
    end
    for (int j = 0; j < WBW; j++) begin
      wb_vld[j] = 0; wb_mispred[j] = 0;
      wb_value[j] = $urandom; wb_addr[j] = $urandom & 32'hFFFF_FFFC;
      wb_tag[j] = '0;
      if (($urandom % 100) < p_wb) begin
        for (int t = 0; t < 4; t++) begin
          int k;
          if (q.size() == 0) break;
          k = $urandom % q.size();
          if (!q[k].done && !used[k]) begin
            used[k] = 1; wb_vld[j] = 1;
            wb_tag[j] = IW'((head_tag + k) % DEPTH);
            wb_mispred[j] = (q[k].kind == 2) && (($urandom % 100) < p_mis);
            break;
          end
        end
      end
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    eval_cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic run(input int n, input int p_disp, input int p_wb, input int p_mis);
    for (int c = 0; c < n; c++) begin
      gen(p_disp, p_wb, p_mis);
      cycle();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    disp_vld = '0; disp_kind = '0; disp_rd = '0;
    wb_vld = '0; wb_tag = '0; wb_value = '0; wb_addr = '0; wb_mispred = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: empty after reset, full group grantable
    disp_vld = '1; disp_kind = '0; disp_rd = '0;
    @(negedge clk);
    chk(ret_vld == '0 && st_we == '0 && rf_we == '0, "R1", "retire idle", ret_vld, 0);
    chk(redir_vld == 1'b0, "R1", "redirect idle", redir_vld, 0);
    chk(disp_gnt == '1, "R1", "grant after reset", disp_gnt, '1);
    disp_vld = '0;
    @(posedge clk); #1;
    run(12, 100, 0, 0);    // R2: fill to full, grants close
    run(12, 0, 60, 0);     // R3 R4 R5 R9: out-of-order completion, drain
    run(3000, 70, 50, 20); // R6 R8: mispredict mixed with retire and dispatch
    run(40, 0, 100, 0);    // drain
    chk(n_flush_ret > 0, "R6", "squash with retire seen", n_flush_ret, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule